// File: doc/BRIEF.md
# Central Trigger Controller with Dead Time

The block sits at the root of a trigger fan-out tree. Each clock cycle it looks at every trigger request source: one request line per downlink, two external inputs, a software strobe written through the register port, and an internal periodic pulser. It picks at most one enabled request and issues it as an accepted trigger. An accepted trigger appears as a one-cycle strobe with a 4-bit trigger type and a 24-bit running trigger number.

After every acceptance, a programmable dead time blocks further acceptance. Physics requests that arrive inside that window are counted as rejected.

Software configures the block and reads its counters through a simple register port. A request carries a valid strobe, a write flag, an 8-bit address and 32-bit data. Read data returns one cycle after the read request. Acceptance counting is expressed by the trigger number itself. The rejection count and one raw incoming-request count per downlink are readable.

Top module: `trig_central`

Register addresses (8-bit):

| Address | Access | Contents |
|---|---|---|
| 0x00 | read/write | bit 0 system enable, bit 1 pulser enable, bits 3:2 external input enables |
| 0x01 | read/write | dead time, bits 15:0 |
| 0x02 | read/write | pulser period, bits 27:0 |
| 0x03 | read/write | pulser trigger type, bits 3:0 |
| 0x04 | read/write | downlink enables, one bit per downlink |
| 0x05 | write only, self-clearing, reads 0 | bit 0 software trigger, bit 1 clear statistics |
| 0x10 | read only | trigger number counter |
| 0x11 | read only | rejection counter |
| 0x20+i | read only | raw request counter of downlink i |

## Requirements
- R1: While the system enable (address 0x00 bit 0) is 0, no trigger is accepted and the rejection counter does not change.
- R2: After an acceptance decided in cycle t with dead-time value D (address 0x01 bits 15:0), no acceptance is made in cycles t+1 to t+D. With D = 0, triggers can be accepted in consecutive cycles.
- R3: The rejection counter (0x11) increments by one in each cycle in which the system is enabled, dead time is active, and at least one enabled physics request is present.
- R4: A request accepted in cycle t produces trigValid high in cycle t+1. trigNum then carries the number of earlier acceptances since reset or clear, starting at 0 and wrapping at 24 bits. Register 0x10 reads the count of acceptances.
- R5: A downlink request line counts as a request only when its enable bit (0x04 bit i) is set. Counter 0x20+i counts every cycle its line is high, whether or not it is enabled.
- R6: With the pulser enabled (0x00 bit 1) and period P > 0 (0x02), the pulser requests once every P cycles. Its first request comes P-1 cycles after the enable takes effect. P = 0 gives no requests.
- R7: A trigger accepted from the pulser carries the type in 0x03. Pulser requests count as physics for R3 only when that type is 0x1; type 0xd (calibration) is never counted as rejected.
- R8: Writing 1 to 0x05 bit 0 makes a software request in the cycle of the write. The software request and all external and downlink requests carry type 0x1.
- R9: Writing 1 to 0x05 bit 1 sets the trigger number, the rejection counter and all downlink counters to 0 at the end of that cycle. This takes precedence over any increment in the same cycle.
- R10: External input i counts as a request only when 0x00 bit 2+i is set.
- R11: Priority among simultaneous enabled requests is software, then pulser, then external inputs, then downlinks by ascending index. One trigger at most is accepted per cycle.
- R12: A read returns its data with regRdValid one cycle after the request. It reads the register values as they stood in the request cycle. Reads of 0x05 and unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 8 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data |
| regRdValid | output | 1 | Read data valid |
| extTrig | input | 2 | External trigger requests |
| dlTrig | input | NUM_DL | Downlink trigger requests |
| trigValid | output | 1 | Accepted-trigger strobe |
| trigType | output | 4 | Type of the accepted trigger |
| trigNum | output | 24 | Number of the accepted trigger |

## Verification
The bench runs a cycle-level model built from the requirements. It compares every strobe, type and number, and targets the following corner cases:

- **Zero dead time.** A design that blocks one cycle too many would drop back-to-back triggers.
- **Dead time ending.** An off-by-one here would accept one cycle early or late.
- **Calibration pulser requests inside dead time.** A design that counted these as rejections would inflate the rejection counter.
- **Clear in the same cycle as an acceptance.** A clear that lost priority would leave the counter at 1.
- **Disabled downlinks.** Raw counters must keep counting while no trigger comes out.
- **Simultaneous requests.** These expose a wrong priority order through the type on the strobe.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam logic [7:0] ADR_CTRL   = 8'h00;
  localparam logic [7:0] ADR_DEAD   = 8'h01;
  localparam logic [7:0] ADR_PERIOD = 8'h02;
  localparam logic [7:0] ADR_PTYPE  = 8'h03;
  localparam logic [7:0] ADR_DLEN   = 8'h04;
  localparam logic [7:0] ADR_CMD    = 8'h05;
  localparam logic [7:0] ADR_NUM    = 8'h10;
  localparam logic [7:0] ADR_REJ    = 8'h11;
  localparam logic [7:0] ADR_DLBASE = 8'h20;
  localparam logic [3:0] TYPE_PHYS  = 4'h1;

  typedef struct packed {
    logic       accept;
    logic       reject;
    logic       clear;
    logic [3:0] kind;
  } trigStb_t;
endpackage

// File: rtl/trig_pulser.sv
module trig_pulser #(
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [PER_W-1:0] period,
  output logic             fire
);
  logic [PER_W-1:0] cnt;

  assign fire = enable && (period != '0) && (cnt >= period - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (!enable || fire) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_DL = 4,
  parameter int DEAD_W = 16,
  parameter int PER_W  = 28,
  parameter int TNUM_W = 24,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regValid,
  input  logic                    regWrite,
  input  logic [7:0]              regAddr,
  input  logic [DATA_W-1:0]       regWdata,
  output logic [DATA_W-1:0]       regRdata,
  output logic                    regRdValid,
  input  logic [1:0]              extTrig,
  input  logic [NUM_DL-1:0]       dlTrig,
  input  logic [TNUM_W-1:0]       numCnt,
  input  logic [CNT_W-1:0]        rejCnt,
  input  logic [NUM_DL*CNT_W-1:0] dlCnt,
  output trigStb_t                stb,
  output logic                    sysEnable,
  output logic [DEAD_W-1:0]       deadCfg
);
  localparam int NREQ = 4 + NUM_DL;

  logic              pulserEn;
  logic [1:0]        extEn;
  logic [PER_W-1:0]  periodCfg;
  logic [3:0]        pulserType;
  logic [NUM_DL-1:0] dlEn;
  logic [DEAD_W-1:0] deadCnt;
  logic              pulseFire;
  logic              wrEn, swReq, clrReq, deadActive;
  logic [NREQ-1:0]   reqVec, physVec;
  logic [DATA_W-1:0] rdMux;

  trig_pulser #(.PER_W(PER_W)) uPulser (
    .clk(clk), .rstN(rstN), .enable(pulserEn), .period(periodCfg), .fire(pulseFire)
  );

  assign wrEn       = regValid && regWrite;
  assign swReq      = wrEn && (regAddr == ADR_CMD) && regWdata[0];
  assign clrReq     = wrEn && (regAddr == ADR_CMD) && regWdata[1];
  assign deadActive = (deadCnt != '0);

  // bit order is the priority order: lowest set bit wins
  assign reqVec  = {dlTrig & dlEn, extTrig & extEn, pulseFire, swReq};
  assign physVec = {reqVec[NREQ-1:2], reqVec[1] && (pulserType == TYPE_PHYS), reqVec[0]};

  always_comb begin
    stb.accept = sysEnable && !deadActive && (|reqVec);
    stb.reject = sysEnable && deadActive && (|physVec);
    stb.clear  = clrReq;
    stb.kind   = (!reqVec[0] && reqVec[1]) ? pulserType : TYPE_PHYS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysEnable  <= 1'b0;
      pulserEn   <= 1'b0;
      extEn      <= '0;
      deadCfg    <= '0;
      periodCfg  <= '0;
      pulserType <= TYPE_PHYS;
      dlEn       <= '0;
    end else if (wrEn) begin
      case (regAddr)
        ADR_CTRL: begin
          sysEnable <= regWdata[0];
          pulserEn  <= regWdata[1];
          extEn     <= regWdata[3:2];
        end
        ADR_DEAD:   deadCfg    <= regWdata[DEAD_W-1:0];
        ADR_PERIOD: periodCfg  <= regWdata[PER_W-1:0];
        ADR_PTYPE:  pulserType <= regWdata[3:0];
        ADR_DLEN:   dlEn       <= regWdata[NUM_DL-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deadCnt <= '0;
    else if (stb.accept) deadCnt <= deadCfg;
    else if (deadActive) deadCnt <= deadCnt - 1'b1;
  end

  always_comb begin
    rdMux = '0;
    case (regAddr)
      ADR_CTRL:   rdMux[3:0] = {extEn, pulserEn, sysEnable};
      ADR_DEAD:   rdMux[DEAD_W-1:0] = deadCfg;
      ADR_PERIOD: rdMux[PER_W-1:0] = periodCfg;
      ADR_PTYPE:  rdMux[3:0] = pulserType;
      ADR_DLEN:   rdMux[NUM_DL-1:0] = dlEn;
      ADR_NUM:    rdMux[TNUM_W-1:0] = numCnt;
      ADR_REJ:    rdMux[CNT_W-1:0] = rejCnt;
      default: ;
    endcase
    for (int i = 0; i < NUM_DL; i++) begin
      if (regAddr == ADR_DLBASE + 8'(i)) rdMux[CNT_W-1:0] = dlCnt[i*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdValid <= 1'b0;
      regRdata   <= '0;
    end else begin
      regRdValid <= regValid && !regWrite;
      regRdata   <= (regValid && !regWrite) ? rdMux : '0;
    end
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_DL = 4,
  parameter int TNUM_W = 24,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  trigStb_t                stb,
  input  logic [NUM_DL-1:0]       dlTrig,
  output logic                    trigValid,
  output logic [3:0]              trigType,
  output logic [TNUM_W-1:0]       trigNum,
  output logic [TNUM_W-1:0]       numCnt,
  output logic [CNT_W-1:0]        rejCnt,
  output logic [NUM_DL*CNT_W-1:0] dlCnt
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigValid <= 1'b0;
      trigType  <= '0;
      trigNum   <= '0;
      numCnt    <= '0;
      rejCnt    <= '0;
    end else begin
      trigValid <= stb.accept;
      trigType  <= stb.accept ? stb.kind : 4'h0;
      trigNum   <= stb.accept ? numCnt : '0;
      numCnt    <= stb.clear ? '0 : numCnt + TNUM_W'(stb.accept);
      rejCnt    <= stb.clear ? '0 : rejCnt + CNT_W'(stb.reject);
    end
  end

  for (genvar i = 0; i < NUM_DL; i++) begin : gDlCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dlCnt[i*CNT_W +: CNT_W] <= '0;
      else if (stb.clear) dlCnt[i*CNT_W +: CNT_W] <= '0;
      else dlCnt[i*CNT_W +: CNT_W] <= dlCnt[i*CNT_W +: CNT_W] + CNT_W'(dlTrig[i]);
    end
  end
endmodule

// File: rtl/trig_central.sv
module trig_central
  import trig_pkg::*;
#(
  parameter int NUM_DL = 4,
  parameter int DEAD_W = 16,
  parameter int PER_W  = 28,
  parameter int TNUM_W = 24,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regRdValid,
  input  logic [1:0]        extTrig,
  input  logic [NUM_DL-1:0] dlTrig,
  output logic              trigValid,
  output logic [3:0]        trigType,
  output logic [TNUM_W-1:0] trigNum
);
  trigStb_t                stb;
  logic                    sysEnable;
  logic [DEAD_W-1:0]       deadCfg;
  logic [TNUM_W-1:0]       numCnt;
  logic [CNT_W-1:0]        rejCnt;
  logic [NUM_DL*CNT_W-1:0] dlCnt;

  trig_ctrl #(
    .NUM_DL(NUM_DL), .DEAD_W(DEAD_W), .PER_W(PER_W),
    .TNUM_W(TNUM_W), .CNT_W(CNT_W), .DATA_W(32)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRdValid(regRdValid), .extTrig(extTrig), .dlTrig(dlTrig),
    .numCnt(numCnt), .rejCnt(rejCnt), .dlCnt(dlCnt), .stb(stb),
    .sysEnable(sysEnable), .deadCfg(deadCfg)
  );

  trig_datapath #(.NUM_DL(NUM_DL), .TNUM_W(TNUM_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .dlTrig(dlTrig),
    .trigValid(trigValid), .trigType(trigType), .trigNum(trigNum),
    .numCnt(numCnt), .rejCnt(rejCnt), .dlCnt(dlCnt)
  );
endmodule

// File: rtl/trig_central_chk.sv
module trig_central_chk #(
  parameter int DEAD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sysEnable,
  input logic [DEAD_W-1:0] deadCfg,
  input logic              accStb,
  input logic              rejStb,
  input logic              trigValid
);
  logic [DEAD_W-1:0] deadPrev;
  logic [DEAD_W-1:0] holdLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deadPrev <= '0;
      holdLeft <= '0;
    end else begin
      deadPrev <= deadCfg;
      if (trigValid) holdLeft <= deadPrev;
      else if (holdLeft != '0) holdLeft <= holdLeft - 1'b1;
    end
  end

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !sysEnable |=> !trigValid);

  p_dead_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    trigValid |-> (holdLeft == '0));

  p_reject_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    rejStb |-> !accStb);

  p_accept_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    accStb |=> trigValid);

  p_no_strobe_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !accStb |=> !trigValid);
endmodule

bind trig_central trig_central_chk u_chk (
  .clk(clk), .rstN(rstN), .sysEnable(sysEnable), .deadCfg(deadCfg),
  .accStb(stb.accept), .rejStb(stb.reject), .trigValid(trigValid)
);

// File: tb/tb_trig_central.sv
module tb_trig_central;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regRdValid;
  logic [1:0]  extTrig = '0;
  logic [ND-1:0] dlTrig = '0;
  logic        trigValid;
  logic [3:0]  trigType;
  logic [23:0] trigNum;

  int checks = 0, errors = 0;
  string curTag = "R4";

  trig_central #(.NUM_DL(ND)) dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRdValid(regRdValid), .extTrig(extTrig), .dlTrig(dlTrig),
    .trigValid(trigValid), .trigType(trigType), .trigNum(trigNum)
  );

  always #5 clk = ~clk;

  // model state, built from the requirements
  logic        mEn, mPen;
  logic [1:0]  mExtEn;
  logic [15:0] mDead, mDeadCnt;
  logic [27:0] mPer, mPulCnt;
  logic [3:0]  mPtype;
  logic [ND-1:0] mDlEn;
  logic [23:0] mNum;
  logic [31:0] mRej;
  logic [31:0] mDl [ND];
  logic        eValid, eRdV;
  logic [3:0]  eType;
  logic [23:0] eNum;
  logic [31:0] eRd;
  int          strobeCnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h00: v[3:0] = {mExtEn, mPen, mEn};
      8'h01: v[15:0] = mDead;
      8'h02: v[27:0] = mPer;
      8'h03: v[3:0] = mPtype;
      8'h04: v[ND-1:0] = mDlEn;
      8'h10: v[23:0] = mNum;
      8'h11: v = mRej;
      default: ;
    endcase
    for (int i = 0; i < ND; i++) if (a == 8'h20 + 8'(i)) v = mDl[i];
    return v;
  endfunction

  task automatic modelReset();
    mEn = 0; mPen = 0; mExtEn = 0; mDead = 0; mDeadCnt = 0; mPer = 0; mPulCnt = 0;
    mPtype = 4'h1; mDlEn = 0; mNum = 0; mRej = 0; eValid = 0; eRdV = 0;
    eType = 0; eNum = 0; eRd = 0;
    for (int i = 0; i < ND; i++) mDl[i] = 0;
  endtask

  // one cycle: drive, predict, wait an edge, compare at the falling edge
  task automatic tick(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [31:0] d, input logic [1:0] ext, input logic [ND-1:0] dl);
    logic swR, clr, fire, acc, rej;
    logic [ND+3:0] req, phys;
    regValid = wr | rd; regWrite = wr; regAddr = a; regWdata = d;
    extTrig = ext; dlTrig = dl;
    swR  = wr && a == 8'h05 && d[0];
    clr  = wr && a == 8'h05 && d[1];
    fire = mPen && mPer != 0 && mPulCnt >= mPer - 1;
    req  = {dl & mDlEn, ext & mExtEn, fire, swR};
    phys = req; phys[1] = req[1] && (mPtype == 4'h1);
    acc  = mEn && mDeadCnt == 0 && (|req);
    rej  = mEn && mDeadCnt != 0 && (|phys);
    eValid = acc;
    eType  = (!req[0] && req[1]) ? mPtype : 4'h1;
    eNum   = mNum;
    eRdV   = rd;
    eRd    = rd ? mRead(a) : 32'h0;
    mNum = clr ? 24'h0 : mNum + 24'(acc);
    mRej = clr ? 32'h0 : mRej + 32'(rej);
    for (int i = 0; i < ND; i++) mDl[i] = clr ? 32'h0 : mDl[i] + 32'(dl[i]);
    if (acc) mDeadCnt = mDead; else if (mDeadCnt != 0) mDeadCnt = mDeadCnt - 1;
    if (!mPen || fire) mPulCnt = 0; else mPulCnt = mPulCnt + 1;
    if (wr) case (a)
      8'h00: begin mEn = d[0]; mPen = d[1]; mExtEn = d[3:2]; end
      8'h01: mDead = d[15:0];
      8'h02: mPer = d[27:0];
      8'h03: mPtype = d[3:0];
      8'h04: mDlEn = d[ND-1:0];
      default: ;
    endcase
    @(posedge clk); @(negedge clk);
    chk({curTag, " strobe"}, 32'(trigValid), 32'(eValid));
    if (eValid) begin
      strobeCnt++;
      chk({curTag, " type"}, 32'(trigType), 32'(eType));
      chk({curTag, " number"}, 32'(trigNum), 32'(eNum));
    end
    chk("R12 rdvalid", 32'(regRdValid), 32'(eRdV));
    if (eRdV) chk({curTag, " R12 rdata"}, regRdata, eRd);
    regValid = 0; regWrite = 0;
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    tick(1, 0, a, d, 2'b00, '0);
  endtask
  task automatic rdReg(input logic [7:0] a);
    tick(0, 1, a, 32'h0, 2'b00, '0);
  endtask
  task automatic idle(input int n, input logic [1:0] ext, input logic [ND-1:0] dl);
    for (int i = 0; i < n; i++) tick(0, 0, 8'h00, 32'h0, ext, dl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rejBefore;
    void'($urandom(32'd20240607));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R4 reset";
    chk("R4 reset trigValid", 32'(trigValid), 0);
    rdReg(8'h10); rdReg(8'h11); rdReg(8'h00);
    curTag = "R12"; rdReg(8'h05); rdReg(8'h3f);

    // R1: disabled system, enabled downlinks
    curTag = "R1";
    wrReg(8'h04, 32'hf);
    idle(5, 2'b00, 4'b1111);
    rdReg(8'h11);
    tick(1, 0, 8'h05, 32'h1, 2'b00, '0);

    // R2: zero dead time gives back-to-back triggers
    curTag = "R2";
    wrReg(8'h00, 32'h1);
    strobeCnt = 0;
    idle(6, 2'b00, 4'b0100);
    chk("R2 back-to-back count", 32'(strobeCnt), 6);

    // R2/R3: dead time 3 with a continuous physics request
    curTag = "R3";
    wrReg(8'h01, 32'd3);
    strobeCnt = 0;
    idle(12, 2'b00, 4'b0001);
    chk("R2 dead time 3 count", 32'(strobeCnt), 3);
    rdReg(8'h11);

    // R5: disabled downlink still counted
    curTag = "R5";
    wrReg(8'h01, 32'd0);
    wrReg(8'h04, 32'h1);
    strobeCnt = 0;
    idle(4, 2'b00, 4'b1000);
    chk("R5 disabled downlink no trigger", 32'(strobeCnt), 0);
    rdReg(8'h23); rdReg(8'h20);

    // R10: external enables
    curTag = "R10";
    idle(3, 2'b11, '0);
    wrReg(8'h00, 32'h9);
    strobeCnt = 0;
    idle(3, 2'b01, '0);
    chk("R10 ext0 disabled", 32'(strobeCnt), 0);
    idle(3, 2'b10, '0);
    chk("R10 ext1 enabled", 32'(strobeCnt), 3);

    // R6/R7: pulser period 5 with calibration type
    curTag = "R7";
    wrReg(8'h03, 32'hd);
    wrReg(8'h02, 32'd5);
    wrReg(8'h00, 32'h3);
    strobeCnt = 0;
    idle(20, 2'b00, '0);
    chk("R6 pulser count in 20 cycles", 32'(strobeCnt), 4);
    // calibration pulses inside dead time are not counted as rejected
    wrReg(8'h01, 32'd9);
    wrReg(8'h02, 32'd2);
    rejBefore = int'(mRej);
    idle(20, 2'b00, '0);
    chk("R7 calibration not rejected", mRej, 32'(rejBefore));
    rdReg(8'h11);
    curTag = "R6";
    wrReg(8'h02, 32'd0);
    wrReg(8'h01, 32'd0);
    strobeCnt = 0;
    idle(10, 2'b00, '0);
    chk("R6 zero period silent", 32'(strobeCnt), 0);

    // R11: priority via type; R8 software trigger
    curTag = "R11";
    wrReg(8'h02, 32'd4);
    wrReg(8'h00, 32'hf);
    idle(12, 2'b11, 4'b0001);
    curTag = "R8";
    tick(1, 0, 8'h05, 32'h1, 2'b00, '0);
    chk("R8 soft trigger type", 32'(trigType), 32'h1);

    // R9: clear together with an acceptance
    curTag = "R9";
    wrReg(8'h00, 32'h1);
    idle(2, 2'b00, 4'b0001);
    tick(1, 0, 8'h05, 32'h3, 2'b00, 4'b0011);
    rdReg(8'h10); rdReg(8'h11); rdReg(8'h20); rdReg(8'h21);

    // random phase
    curTag = "R11 random";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      logic [1:0] ex = 2'($urandom);
      logic [ND-1:0] dl = ND'($urandom) & ND'($urandom);
      if (r < 3) begin
        int sel = int'($urandom_range(0, 4));
        logic [31:0] d = $urandom;
        logic [7:0] a = 8'(sel);
        if (sel == 0) d[0] = ($urandom_range(0, 9) != 0);
        if (sel == 1) d = 32'($urandom_range(0, 5));
        if (sel == 2) d = 32'($urandom_range(0, 7));
        if (sel == 3) d = ($urandom_range(0, 1) != 0) ? 32'h1 : 32'hd;
        tick(1, 0, a, d, ex, dl);
      end else if (r < 5) begin
        tick(1, 0, 8'h05, 32'h1, ex, dl);
      end else if (r < 6) begin
        tick(1, 0, 8'h05, 32'h2, ex, dl);
      end else if (r < 12) begin
        logic [7:0] ra [7] = '{8'h10, 8'h11, 8'h20, 8'h21, 8'h22, 8'h23, 8'h00};
        tick(0, 1, ra[$urandom_range(0, 6)], 32'h0, ex, dl);
      end else begin
        tick(0, 0, 8'h00, 32'h0, ex, dl);
      end
    end
    curTag = "R3 final";
    rdReg(8'h11);
    curTag = "R4 final";
    rdReg(8'h10);
    curTag = "R5 final";
    for (int i = 0; i < ND; i++) rdReg(8'h20 + 8'(i));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule